// File: doc/BRIEF.md
# Looping Pattern Memory Pulse Player

This block is one pulse-generator channel. A serial bit pattern is first written into a small internal one-bit-wide memory through a plain address, data and write-enable port. A 2-bit mode field then starts playback. In playback the channel reads the pattern one bit per clock and drives it onto a single output pin.

Three modes are defined. Stopped produces no output. Loop replays the pattern without end. Once plays the pattern a single time, after which the channel stops itself and writes its own mode field back to stopped. A 16-bit wrap index sets the pattern length, so the read pointer returns to zero well before the end of the memory when needed. A running status bit shows when the channel is generating. A separate output-enable bit gates the pin without pausing the pointer.

A second channel is made by instantiating the block again.

The control states are:
- `ST_IDLE`: stopped.
- `ST_LOOP`: endless playback.
- `ST_ONCE`: a single pass.

The transitions are:
- start-loop: `ST_IDLE`→`ST_LOOP` when the mode reads 1.
- start-once: `ST_IDLE`→`ST_ONCE` when the mode reads 2.
- switch: `ST_LOOP`↔`ST_ONCE` when the mode changes between 1 and 2.
- finish: `ST_ONCE`→`ST_IDLE` after the last bit, with the mode cleared.
- halt: any playing state→`ST_IDLE` when the mode reads 0 or 3.

Top module: `pattern_player`

## Requirements
- R1: After reset, `mode_q` reads 0, `running` is 0 and `pulse_out` is 0.
- R2: Mode 1 replays memory bits 0 to L-1 in order, one per clock, without end, where L = `wrap_idx` when `wrap_idx` ≥ 1.
- R3: The pointer goes back to 0 after index `wrap_idx`-1. A `wrap_idx` of 0 or 1 gives a one-bit pattern: bit 0 repeated.
- R4: Mode 2 plays bits 0 to L-1 once. On the clock after the last bit, `running` and `pulse_out` go to 0 and `mode_q` reads 0.
- R5: Modes 0 and 3 both keep the channel stopped: `running` and `pulse_out` stay 0.
- R6: When the channel leaves stopped for mode 1 or 2, `running` rises one clock after `mode_q` takes the new value, and the first bit output is memory bit 0.
- R7: With `out_en` = 0, `pulse_out` is 0. The pointer keeps advancing, so on re-enable the output shows the bit the pattern has reached by then.
- R8: `running` is 1 exactly while the channel is in a playing state. When `running` is 0, `pulse_out` is 0.
- R9: A mode write through `mode_wr` in the same clock as a one-shot finish takes priority over the self-clear.
- R10: With `mem_we` = 1, `mem_data` is stored at `mem_addr` on the clock edge. The stored bit is read by playback from the following cycle, including during playback.
- R11: Writing mode 0 during playback stops the channel one clock after `mode_q` reads 0. A later start begins again at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Load `mode_in` into the mode field |
| mode_in | input | 2 | New mode: 0 stop, 1 loop, 2 once, 3 stop |
| mode_q | output | 2 | Current mode field |
| out_en | input | 1 | Output enable for `pulse_out` |
| wrap_idx | input | 16 | Pattern length; the pointer returns to 0 at this index |
| mem_we | input | 1 | Pattern memory write enable |
| mem_addr | input | ADDR_W | Pattern memory write address |
| mem_data | input | 1 | Pattern bit to write |
| pulse_out | output | 1 | Serial pattern output |
| running | output | 1 | Channel is generating pulses |

## Verification
A wrong state or pointer shows at `pulse_out` within one clock, because each cycle's output bit is selected directly by the pointer. A stuck or wrongly cleared mode field shows at `mode_q` and `running` one clock after the event that should have changed it. The bench's reference model predicts all three outputs for every cycle. A bad wrap length, a missed pointer reset on restart, or a pointer that wrongly freezes while the output is disabled is therefore caught on the first wrong bit. It is not left for an end-of-pass check.

// File: rtl/pp_pkg.sv
package pp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOOP = 2'd1,
        ST_ONCE = 2'd2
    } play_st_t;

    localparam logic [1:0] MODE_STOP = 2'd0;
    localparam logic [1:0] MODE_LOOP = 2'd1;
    localparam logic [1:0] MODE_ONCE = 2'd2;
endpackage

// File: rtl/pp_mode_reg.sv
module pp_mode_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_val,
    input  logic       self_clr,
    output logic [1:0] mode
);
    import pp_pkg::*;

    // bus write wins over the channel's own clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        mode <= MODE_STOP;
        else if (wr_en)    mode <= wr_val;
        else if (self_clr) mode <= MODE_STOP;
    end
endmodule

// File: rtl/pp_pattern_mem.sv
module pp_pattern_mem #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic              wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic              rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/pp_play_fsm.sv
module pp_play_fsm #(
    parameter int IDX_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic [IDX_W-1:0] wrap,
    output logic [IDX_W-1:0] ptr,
    output logic             finish,
    output logic             running
);
    import pp_pkg::*;

    play_st_t         st, st_n;
    logic [IDX_W-1:0] ptr_n;
    logic [IDX_W:0]   ptr_inc;
    logic             at_last;
    logic             want_play;

    assign ptr_inc   = {1'b0, ptr} + {{IDX_W{1'b0}}, 1'b1};
    assign at_last   = ptr_inc >= {1'b0, wrap};
    assign want_play = (mode == MODE_LOOP) || (mode == MODE_ONCE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            ptr <= '0;
        end else begin
            st  <= st_n;
            ptr <= ptr_n;
        end
    end

    // next state and pointer
    always_comb begin
        st_n   = st;
        ptr_n  = ptr;
        finish = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (want_play) begin
                    st_n  = (mode == MODE_LOOP) ? ST_LOOP : ST_ONCE;
                    ptr_n = '0;
                end
            end
            ST_LOOP, ST_ONCE: begin
                if (st == ST_ONCE && mode == MODE_ONCE && at_last) begin
                    st_n   = ST_IDLE;
                    ptr_n  = '0;
                    finish = 1'b1;
                end else if (want_play) begin
                    st_n  = (mode == MODE_LOOP) ? ST_LOOP : ST_ONCE;
                    ptr_n = at_last ? '0 : ptr_inc[IDX_W-1:0];
                end else begin
                    st_n = ST_IDLE;
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        running = (st != ST_IDLE);
    end
endmodule

// File: rtl/pattern_player.sv
module pattern_player #(
    parameter int ADDR_W = 6,
    parameter int IDX_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic [1:0]        mode_in,
    output logic [1:0]        mode_q,
    input  logic              out_en,
    input  logic [IDX_W-1:0]  wrap_idx,
    input  logic              mem_we,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_data,
    output logic              pulse_out,
    output logic              running
);
    logic [IDX_W-1:0] rd_ptr;
    logic             pass_done;
    logic             rd_bit;

    pp_mode_reg u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (mode_wr),
        .wr_val   (mode_in),
        .self_clr (pass_done),
        .mode     (mode_q)
    );

    pp_play_fsm #(.IDX_W(IDX_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode_q),
        .wrap    (wrap_idx),
        .ptr     (rd_ptr),
        .finish  (pass_done),
        .running (running)
    );

    pp_pattern_mem #(.ADDR_W(ADDR_W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_addr),
        .wdata (mem_data),
        .raddr (rd_ptr[ADDR_W-1:0]),
        .rdata (rd_bit)
    );

    assign pulse_out = running & out_en & rd_bit;
endmodule

// File: rtl/pp_checker.sv
module pp_checker #(
    parameter int IDX_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_wr,
    input logic [1:0]       mode_q,
    input logic             out_en,
    input logic             pulse_out,
    input logic             running,
    input logic [IDX_W-1:0] rd_ptr
);
    // R8
    stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !pulse_out);

    // R7
    oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> !pulse_out);

    // R5
    stay_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !mode_wr && (mode_q == 2'd0 || mode_q == 2'd3)) |=> !running);

    // R6
    start_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> (rd_ptr == '0));

    // R4
    once_clears_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(running) && $past(mode_q) == 2'd2 && !$past(mode_wr)) |-> (mode_q == 2'd0));
endmodule

bind pattern_player pp_checker #(.IDX_W(IDX_W)) u_pp_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_wr   (mode_wr),
    .mode_q    (mode_q),
    .out_en    (out_en),
    .pulse_out (pulse_out),
    .running   (running),
    .rd_ptr    (rd_ptr)
);

// File: tb/tb_pattern_player.sv
module tb_pattern_player;
    localparam int AW = 6;
    localparam int IW = 16;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_wr = 1'b0;
    logic [1:0]    mode_in = 2'd0;
    logic [1:0]    mode_q;
    logic          out_en = 1'b0;
    logic [IW-1:0] wrap_idx = '0;
    logic          mem_we = 1'b0;
    logic [AW-1:0] mem_addr = '0;
    logic          mem_data = 1'b0;
    logic          pulse_out;
    logic          running;

    always #4 clk = ~clk;

    pattern_player #(.ADDR_W(AW), .IDX_W(IW)) dut (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_in(mode_in),
        .mode_q(mode_q), .out_en(out_en), .wrap_idx(wrap_idx),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data),
        .pulse_out(pulse_out), .running(running)
    );

    int    checks = 0;
    int    fails  = 0;
    string req    = "R1";

    // behavioural reference model
    bit m_run;
    int m_kind;
    int m_mode;
    int m_ptr;
    bit m_mem [DEPTH];

    always @(posedge clk) begin
        int len;
        bit last;
        bit fin;
        fin = 1'b0;
        if (!rst_n) begin
            m_run = 0; m_mode = 0; m_ptr = 0; m_kind = 0;
        end else begin
            len  = (int'(wrap_idx) <= 1) ? 1 : int'(wrap_idx);
            last = (m_ptr + 1 >= len);
            if (!m_run) begin
                if (m_mode == 1 || m_mode == 2) begin
                    m_run = 1; m_kind = m_mode; m_ptr = 0;
                end
            end else if (m_mode == 2 && m_kind == 2 && last) begin
                m_run = 0; m_ptr = 0; fin = 1'b1;
            end else if (m_mode == 1 || m_mode == 2) begin
                m_kind = m_mode;
                m_ptr  = last ? 0 : m_ptr + 1;
            end else begin
                m_run = 0;
            end
            if (mode_wr)  m_mode = int'(mode_in);
            else if (fin) m_mode = 0;
        end
        if (mem_we) m_mem[mem_addr] = mem_data;
    end

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %0h expected %0h at %0t", r, act, exp, $time);
        end
    endtask

    task automatic tick();
        logic [3:0] exp;
        @(negedge clk);
        exp = {m_run & out_en & m_mem[m_ptr % DEPTH], m_run, m_mode[1:0]};
        chk(req, {28'd0, pulse_out, running, mode_q}, {28'd0, exp});
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr_mode(input logic [1:0] v);
        mode_in = v; mode_wr = 1'b1;
        tick();
        mode_wr = 1'b0;
    endtask

    task automatic wr_mem(input int a, input bit d);
        mem_we = 1'b1; mem_addr = AW'(a); mem_data = d;
        tick();
        mem_we = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        #1_000_000;
        checks++; fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        // R1: reset state
        for (int i = 0; i < DEPTH; i++) m_mem[i] = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", {29'd0, pulse_out, mode_q}, 32'd0);
        chk("R1", {31'd0, running}, 32'd0);
        rst_n = 1'b1;
        ticks(2);

        // R10: load the pattern while stopped
        req = "R10";
        for (int i = 0; i < DEPTH; i++) wr_mem(i, ((i * 7 + 3) % 5) < 2);
        out_en = 1'b1;

        // R2/R6: endless loop, length 10
        req = "R6";
        wrap_idx = 16'd10;
        wr_mode(2'd1);
        ticks(2);
        chk("R6", {31'd0, running}, 32'd1);
        req = "R2";
        ticks(33);

        // R7: output disabled, pointer keeps moving
        req = "R7";
        out_en = 1'b0;
        ticks(7);
        out_en = 1'b1;
        ticks(6);

        // R10: rewrite bits during playback
        req = "R10";
        wr_mem(2, 1'b1);
        wr_mem(3, 1'b0);
        wr_mem(5, 1'b1);
        ticks(12);

        // R11: stop mid-play, then restart from bit 0
        req = "R11";
        wr_mode(2'd0);
        ticks(4);
        chk("R11", {31'd0, running}, 32'd0);
        wr_mode(2'd1);
        ticks(8);

        // R3: short wrap values
        req = "R3";
        wrap_idx = 16'd0;
        ticks(6);
        wrap_idx = 16'd1;
        ticks(4);
        wrap_idx = 16'd3;
        ticks(9);

        // R4: one-shot pass of 6 bits
        req = "R4";
        wr_mode(2'd0);
        ticks(3);
        wrap_idx = 16'd6;
        wr_mode(2'd2);
        ticks(12);
        chk("R4", {30'd0, mode_q}, 32'd0);
        chk("R4", {30'd0, running, pulse_out}, 32'd0);

        // R5: reserved mode keeps channel stopped
        req = "R5";
        wr_mode(2'd3);
        ticks(10);
        chk("R5", {30'd0, running, pulse_out}, 32'd0);
        wr_mode(2'd0);
        ticks(2);

        // R9: bus write lands on the finish edge
        req = "R9";
        wrap_idx = 16'd4;
        wr_mode(2'd2);
        ticks(4);
        wr_mode(2'd1);
        chk("R9", {30'd0, mode_q}, 32'd1);
        ticks(10);

        // R8: running tracks playing state through a stop
        req = "R8";
        wr_mode(2'd0);
        ticks(3);
        chk("R8", {31'd0, running}, 32'd0);

        summary();
        $finish;
    end
endmodule